// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns bytes into an asynchronous serial bit stream. Bytes are written into a small holding queue. A shifter takes the oldest byte and sends a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop period. Every bit lasts 16 pulses of an external baud tick, which arrives at 16 times the bit rate. The divider that makes that tick lives outside this block. When no tick arrives the shifter does not advance.

A 7-bit format control input selects the frame layout. The fields are: word length in bits [1:0] (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits), a long-stop select in bit 2, parity enable in bit 3, even-parity select in bit 4, stick parity in bit 5, and a break request in bit 6. The format is captured when each character starts, so a change mid-frame takes effect on the next character. The break request acts on the line at once.

Two status outputs tell software-facing logic what state the transmitter is in. One says that the holding queue is empty. The other says that the queue is empty and the shifter is idle as well.

Top module: `sertx_framer`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `line_idle` is 1.
- R2: A frame starts with a low start bit of 16 ticks. Then `5 + fmt_ctrl[1:0]` data bits follow, each 16 ticks long and sent from the least significant bit up. Bits of `wr_data` above the word length are not sent. Between ticks the line level does not change.
- R3: When `fmt_ctrl[3]` is 1, one 16-tick parity bit follows the data. With `fmt_ctrl[4]` = 1 it makes the count of ones in the data plus parity even; with `fmt_ctrl[4]` = 0 it makes that count odd. When `fmt_ctrl[3]` is 0, no parity bit is sent.
- R4: When `fmt_ctrl[5]` and `fmt_ctrl[3]` are both 1, the parity bit is the inverse of `fmt_ctrl[4]`, whatever the data. `fmt_ctrl[5]` has no effect while `fmt_ctrl[3]` is 0.
- R5: The stop period is high and lasts 16 ticks when `fmt_ctrl[2]` is 0. When `fmt_ctrl[2]` is 1 it lasts 32 ticks, except with a 5-bit word (`fmt_ctrl[1:0]` = 00), where it lasts 24 ticks.
- R6: While `fmt_ctrl[6]` is 1, `txd` is 0 in the same cycle, whatever the shifter is doing.
- R7: If a byte is waiting when a stop period ends, its start bit begins on the very next tick, with no idle tick between the frames.
- R8: The holding queue stores up to DEPTH bytes. A write while it is full is dropped, and the bytes already queued are sent unchanged.
- R9: `hold_empty` is 1 exactly when the queue holds no byte. `line_idle` is 1 exactly when the queue is empty and no frame is in progress, and `txd` is then high unless a break is requested.
- R10: The format is sampled when a character is loaded into the shifter. Changing `fmt_ctrl` (other than bit 6) during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| fmt_ctrl | input | 7 | Frame format and break control (fields as described above) |
| wr_en | input | 1 | Write strobe for the holding queue |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding queue is empty |
| line_idle | output | 1 | Queue empty and shifter idle |

## Verification
The bench builds the block with DEPTH = 4 and a baud tick every 4 clocks. The shallow queue means six back-to-back writes overflow it, and the expected stream shows which byte is dropped. The short tick period keeps frames short enough to sweep every combination of word length, parity mode and stop length, with two back-to-back bytes per combination. For each tick the bench compares the line level against a per-tick expected waveform that it computes arithmetically, and it also compares the total frame length.

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [6:0] fmt_ctrl,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       hold_empty,
  output logic       line_idle
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t st;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic [4:0]    tcnt, stop_last;
  logic [2:0]    bidx, last_bit;
  logic [7:0]    shreg, head, mask;
  logic          par_en, par_bit, par_calc;
  logic          have, push, pop, busy, bit_done, frame_done, line_bit;

  assign have       = fill != '0;
  assign push       = wr_en && (fill != CW'(DEPTH));
  assign busy       = st != S_IDLE;
  assign bit_done   = baud_tick && tcnt == 5'd15;
  assign frame_done = (st == S_STOP) && baud_tick && tcnt == stop_last;
  assign pop        = have && (!busy || frame_done);
  assign head       = mem[rp];
  assign mask       = 8'hFF >> (2'd3 - fmt_ctrl[1:0]);
  assign par_calc   = fmt_ctrl[5] ? ~fmt_ctrl[4] : ~(^(head & mask) ^ fmt_ctrl[4]);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      last_bit  <= '0;
      par_en    <= 1'b0;
      par_bit   <= 1'b0;
      stop_last <= 5'd15;
    end else if (pop) begin
      st        <= S_START;
      tcnt      <= '0;
      shreg     <= head;
      last_bit  <= {1'b1, fmt_ctrl[1:0]};
      par_en    <= fmt_ctrl[3];
      par_bit   <= par_calc;
      stop_last <= !fmt_ctrl[2] ? 5'd15 : (fmt_ctrl[1:0] == 2'b00 ? 5'd23 : 5'd31);
    end else if (busy && baud_tick) begin
      if (frame_done) begin
        st   <= S_IDLE;
        tcnt <= '0;
      end else if (st == S_STOP || !bit_done) begin
        tcnt <= tcnt + 5'd1;
      end else begin
        tcnt <= '0;
        case (st)
          S_START: begin
            st   <= S_DATA;
            bidx <= '0;
          end
          S_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 3'd1;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_START: line_bit = 1'b0;
      S_DATA:  line_bit = shreg[0];
      S_PAR:   line_bit = par_bit;
      default: line_bit = 1'b1;
    endcase
  end

  assign txd        = line_bit & ~fmt_ctrl[6];
  assign hold_empty = !have;
  assign line_idle  = !have && !busy;
endmodule

// File: rtl/sertx_framer_chk.sv
module sertx_framer_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       baud_tick,
  input logic                       lcr_brk,
  input logic                       txd,
  input logic                       hold_empty,
  input logic                       line_idle,
  input logic                       busy,
  input logic                       line_bit,
  input logic                       frame_done,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  assert_quiet_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(line_bit));

  assert_start_is_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line_bit);

  assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_brk |-> !txd);

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !hold_empty) |=> (busy && !line_bit));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == ($clog2(DEPTH+1))'(DEPTH) && busy && !frame_done) |=> fill == ($clog2(DEPTH+1))'(DEPTH));

  assert_idle_consistent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> (hold_empty && txd == !lcr_brk));

  always @(posedge clk) begin
    if (rst_n) begin
      assert_fill_bound_R8: assert (fill <= ($clog2(DEPTH+1))'(DEPTH));
    end
  end
endmodule

bind sertx_framer sertx_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .lcr_brk    (fmt_ctrl[6]),
  .txd        (txd),
  .hold_empty (hold_empty),
  .line_idle  (line_idle),
  .busy       (busy),
  .line_bit   (line_bit),
  .frame_done (frame_done),
  .fill       (fill)
);

// File: tb/sertx_framer_tb.sv
module sertx_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int DEPTH = 4;
  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] fmt_ctrl = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txd, hold_empty, line_idle;
  logic [1:0] tdiv;
  logic       tick;

  int checks = 0;
  int fails = 0;
  logic exp_bits [0:4095];
  int   exp_len;
  logic [7:0] txq [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick = (tdiv == 2'(TDIV - 1));

  sertx_framer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .fmt_ctrl(fmt_ctrl),
    .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
    .hold_empty(hold_empty), .line_idle(line_idle)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      exp_bits[exp_len] = v;
      exp_len++;
    end
  endtask

  task automatic add_frame(input logic [6:0] f, input logic [7:0] d);
    int n;
    int ones;
    logic p;
    n = 5 + int'(f[1:0]);
    put(1'b0, 16);
    ones = 0;
    for (int b = 0; b < n; b++) begin
      put(d[b], 16);
      ones += int'(d[b]);
    end
    if (f[3]) begin
      if (f[5]) p = ~f[4];
      else if (f[4]) p = (ones % 2) == 1;
      else p = (ones % 2) == 0;
      put(p, 16);
    end
    if (!f[2]) put(1'b1, 16);
    else if (n == 5) put(1'b1, 24);
    else put(1'b1, 32);
  endtask

  task automatic stream(input logic [6:0] f, input int nw, input int nexp,
                        input logic [6:0] f_after, input string req);
    int j;
    int bad;
    int bad_at;
    logic bad_act;
    exp_len = 0;
    for (int i = 0; i < nexp; i++) add_frame(f, txq[i]);
    fmt_ctrl = f;
    @(negedge clk);
    while (!tick) @(negedge clk);
    j = 0;
    bad = 0;
    bad_at = -1;
    bad_act = 1'b0;
    fork
      begin
        for (int i = 0; i < nw; i++) begin
          @(negedge clk);
          wr_en = 1'b1;
          wr_data = txq[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        fmt_ctrl = f_after;
      end
      begin
        @(negedge clk);
        @(negedge clk);
        while (!line_idle && j < 4096) begin
          if (tick) begin
            if (j >= exp_len || txd !== exp_bits[j]) begin
              if (bad == 0) begin
                bad_at = j;
                bad_act = txd;
              end
              bad++;
            end
            j++;
          end
          @(negedge clk);
        end
      end
    join
    if (bad != 0)
      $display("FAIL %s: fmt=%h first bad tick %0d actual %0d expected %0d",
               req, f, bad_at, bad_act, (bad_at < exp_len) ? exp_bits[bad_at] : 1'b1);
    check({req, " bits"}, bad, 0);
    check({req, " ticks"}, j, exp_len);
    fmt_ctrl = f_after;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 txd", int'(txd), 1);
    check("R1 hold_empty", int'(hold_empty), 1);
    check("R1 line_idle", int'(line_idle), 1);

    // R2 R3 R4 R5 R7: full format sweep, two back-to-back bytes each
    for (int len = 0; len < 4; len++) begin
      for (int pm = 0; pm < 5; pm++) begin
        for (int s = 0; s < 2; s++) begin
          logic [2:0] pb;
          logic [6:0] f;
          case (pm)
            0: pb = 3'b000;
            1: pb = 3'b001;
            2: pb = 3'b011;
            3: pb = 3'b101;
            default: pb = 3'b111;
          endcase
          f = {1'b0, pb, 1'(s), 2'(len)};
          txq[0] = 8'hA5 ^ 8'(len * 37 + pm * 11 + s * 5);
          txq[1] = ~txq[0] ^ 8'(pm * 3);
          stream(f, 2, 2, f, "R2 R3 R4 R5 R7");
        end
      end
    end

    // R4: stick without enable sends no parity bit
    txq[0] = 8'h3C;
    stream(7'b0100011, 1, 1, 7'b0100011, "R4 stick-off");

    // R8: six writes into a 4-deep queue, one byte dropped
    for (int i = 0; i < 6; i++) txq[i] = 8'h11 * 8'(i + 1);
    stream(7'b0000011, 6, 5, 7'b0000011, "R8 overflow");

    // R10: format latched at load
    txq[0] = 8'hC9;
    stream(7'b0011111, 1, 1, 7'b0000000, "R10 latch");

    // R9: flags while a single byte is in flight
    fmt_ctrl = 7'b0000011;
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 hold_empty queued", int'(hold_empty), 0);
    @(negedge clk);
    @(negedge clk);
    check("R9 hold_empty shifting", int'(hold_empty), 1);
    check("R9 line_idle shifting", int'(line_idle), 0);
    check("R2 start low", int'(txd), 0);
    while (!line_idle) @(negedge clk);
    check("R9 txd idle", int'(txd), 1);

    // R6: break forces line low immediately
    fmt_ctrl = 7'b1000011;
    #1;
    check("R6 break low", int'(txd), 0);
    @(negedge clk);
    check("R6 break held", int'(txd), 0);
    fmt_ctrl = 7'b0000011;
    #1;
    check("R6 break released", int'(txd), 1);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule